// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block follows the position of an incremental rotary or linear sensor. The sensor has two square-wave phase outputs, A and B, that are a quarter period apart. The block takes both phases and counts one step on every edge of either of them. A step is added when A leads B and subtracted when B leads A. The count is kept in a 16-bit register that wraps in both directions. Software can overwrite that register at any time, for example to set a home position.

All three sensor inputs (A, B and the index mark) are asynchronous. Each one passes through a two-flop synchronizer before any edge is detected. The index mark never changes the count. Its rising edge only produces a one-cycle interrupt request pulse. If A and B both change between two samples, the phase order cannot be decoded. The count is then left alone and a sticky error flag is raised, which stays set until reset.

Top module: `quad_pos_counter`

## Requirements
- R1: While reset is asserted and just after it is released, with all sensor inputs low, position is 0 and dir_down, index_irq and illegal_err are all 0.
- R2: Phase states are written as {A,B}. The forward sequence is 00, 10, 11, 01, 00 (A leads B). Each forward step adds 1 to position. The new count is visible after the third rising clock edge that follows the input change.
- R3: Each step in the reverse sequence 00, 01, 11, 10, 00 (B leads A) subtracts 1 from position, with the same three-edge latency.
- R4: Position wraps modulo 65536: one step up from 0xFFFF gives 0x0000, and one step down from 0x0000 gives 0xFFFF.
- R5: dir_down becomes 0 on a step up and 1 on a step down. It keeps its value while no step occurs.
- R6: If A and B both change between two synchronized samples (00 to 11, 11 to 00, 10 to 01 or 01 to 10), position does not change. illegal_err is set three edges after the change and stays 1 until reset.
- R7: A rising edge on index_in gives index_irq high for exactly one cycle, three edges after the change. Holding index_in high gives no further pulse, and the index never changes position.
- R8: With wr_en high at a rising edge, position takes wr_data at that edge. This write wins over a count step due at the same edge.
- R9: While the phase inputs are steady and wr_en is low, position does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_a | input | 1 | Sensor phase A, asynchronous |
| phase_b | input | 1 | Sensor phase B, asynchronous |
| index_in | input | 1 | Sensor index mark, asynchronous |
| wr_en | input | 1 | Load position from wr_data |
| wr_data | input | W (16) | Value loaded into position |
| position | output | W (16) | Current sensor position count |
| dir_down | output | 1 | Direction of last step, 1 = down |
| index_irq | output | 1 | One-cycle index interrupt pulse |
| illegal_err | output | 1 | Sticky flag for a two-phase jump |

## Verification
A phase or index change driven at a falling clock edge passes through two synchronizer flops and one decode register. Its effect on position, dir_down, illegal_err or index_irq is therefore due after the third rising edge. The bench waits exactly three rising edges and samples on the falling edge that follows. A register write takes effect at the next rising edge and is sampled one falling edge later. For the write-priority case, the write is placed in the cycle where the pending count step would land. All twelve ordered pairs of distinct phase states are swept. Each expected change is worked out from the position of each state in the forward sequence.

// File: rtl/quad_pos_counter.sv
module quad_pos_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phase_a,
  input  logic         phase_b,
  input  logic         index_in,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] position,
  output logic         dir_down,
  output logic         index_irq,
  output logic         illegal_err
);

  logic [1:0] a_sync, b_sync, i_sync;
  logic       a_prev, b_prev, i_prev;

  wire a_now  = a_sync[1];
  wire b_now  = b_sync[1];
  wire a_chg  = a_now ^ a_prev;
  wire b_chg  = b_now ^ b_prev;
  wire step   = a_chg ^ b_chg;
  wire jump   = a_chg & b_chg;
  wire upward = a_chg ? (a_now ^ b_now) : ~(a_now ^ b_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_sync <= '0;
      b_sync <= '0;
      i_sync <= '0;
      a_prev <= 1'b0;
      b_prev <= 1'b0;
      i_prev <= 1'b0;
    end else begin
      a_sync <= {a_sync[0], phase_a};
      b_sync <= {b_sync[0], phase_b};
      i_sync <= {i_sync[0], index_in};
      a_prev <= a_now;
      b_prev <= b_now;
      i_prev <= i_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      position    <= '0;
      dir_down    <= 1'b0;
      index_irq   <= 1'b0;
      illegal_err <= 1'b0;
    end else begin
      if (wr_en)
        position <= wr_data;
      else if (step)
        position <= upward ? position + 1'b1 : position - 1'b1;
      if (step)
        dir_down <= ~upward;
      if (jump)
        illegal_err <= 1'b1;
      index_irq <= i_sync[1] & ~i_prev;
    end
  end

endmodule

// File: rtl/quad_pos_counter_chk.sv
module quad_pos_counter_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] position,
  input logic         dir_down,
  input logic         index_irq,
  input logic         illegal_err
);

  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> position == $past(wr_data));  // R8

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (position == $past(position) || position == $past(position) + 1'b1
                || position == $past(position) - 1'b1));  // R9

  AST_DIR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (position != $past(position) + 1'b1 || !dir_down));  // R5

  AST_DIR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (position != $past(position) - 1'b1 || dir_down));  // R5

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && position == $past(position)) |-> $stable(dir_down) || $past(wr_en));  // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_err |=> illegal_err);  // R6

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    index_irq |=> !index_irq);  // R7

endmodule

bind quad_pos_counter quad_pos_counter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .position(position), .dir_down(dir_down), .index_irq(index_irq),
  .illegal_err(illegal_err)
);

// File: tb/quad_pos_counter_bench.sv
module quad_pos_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_a = 1'b0, phase_b = 1'b0, index_in = 1'b0, wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] position;
  logic        dir_down, index_irq, illegal_err;

  int checks = 0, failures = 0;
  logic [15:0] exp_pos;
  logic [1:0]  cur;

  always #2 clk = ~clk;

  quad_pos_counter u_quad_pos_counter (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b),
    .index_in(index_in), .wr_en(wr_en), .wr_data(wr_data),
    .position(position), .dir_down(dir_down), .index_irq(index_irq),
    .illegal_err(illegal_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int seq_idx(input logic [1:0] s);
    case (s)
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; phase_a = 1'b0; phase_b = 1'b0; index_in = 1'b0; wr_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cur = 2'b00; exp_pos = 16'h0000;
  endtask

  task automatic drive(input logic [1:0] s);
    phase_a = s[1]; phase_b = s[0];
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_pos(input logic [15:0] v);
    wr_en = 1'b1; wr_data = v;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    exp_pos = v;
  endtask

  // legal step with checks of count and direction
  task automatic step(input logic [1:0] n, input string req);
    int d;
    d = (seq_idx(n) - seq_idx(cur) + 4) % 4;
    drive(n);
    if (d == 1) begin exp_pos = exp_pos + 16'd1; chk({req, " pos up"}, position, exp_pos); chk("R5 dir up", dir_down, 0); end
    else if (d == 3) begin exp_pos = exp_pos - 16'd1; chk({req, " pos down"}, position, exp_pos); chk("R5 dir down", dir_down, 1); end
    cur = n;
  endtask

  function automatic logic [1:0] fwd(input logic [1:0] s);
    case (s) 2'b00: return 2'b10; 2'b10: return 2'b11; 2'b11: return 2'b01; default: return 2'b00; endcase
  endfunction

  function automatic logic [1:0] rev(input logic [1:0] s);
    case (s) 2'b00: return 2'b01; 2'b01: return 2'b11; 2'b11: return 2'b10; default: return 2'b00; endcase
  endfunction

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 position", position, 0);
    chk("R1 dir_down", dir_down, 0);
    chk("R1 index_irq", index_irq, 0);
    chk("R1 illegal_err", illegal_err, 0);

    for (int i = 0; i < 200; i++) step(fwd(cur), "R2");
    for (int i = 0; i < 120; i++) step(rev(cur), "R3");
    chk("R2 R3 net count", position, 16'd80);

    // R9: steady inputs, count holds and direction holds
    repeat (10) @(negedge clk);
    chk("R9 steady", position, exp_pos);
    chk("R5 dir hold", dir_down, 1);

    // R4: wrap in both directions
    write_pos(16'hFFFE);
    chk("R8 write", position, 16'hFFFE);
    for (int i = 0; i < 4; i++) step(fwd(cur), "R4");
    chk("R4 wrap up", position, 16'h0002);
    for (int i = 0; i < 4; i++) step(rev(cur), "R4");
    chk("R4 wrap down", position, 16'hFFFE);

    // R7: index pulse
    index_in = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R7 irq high", index_irq, 1);
    @(negedge clk);
    chk("R7 irq single", index_irq, 0);
    repeat (6) @(negedge clk);
    chk("R7 irq no repeat", index_irq, 0);
    chk("R7 position untouched", position, exp_pos);
    index_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 irq on fall", index_irq, 0);

    // R8: write wins over a step landing at the same edge
    phase_a = fwd(cur)[1]; phase_b = fwd(cur)[0];
    cur = fwd(cur);
    repeat (2) @(posedge clk); @(negedge clk);
    wr_en = 1'b1; wr_data = 16'h1234;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk("R8 write priority", position, 16'h1234);
    repeat (3) @(negedge clk);
    chk("R8 no late step", position, 16'h1234);

    // R2 R3 R6: all ordered pairs of distinct phase states
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 4; n++) begin
        if (p != n) begin
          int d;
          do_reset();
          if (p[1:0] == 2'b10) step(2'b10, "R2");
          else if (p[1:0] == 2'b01) step(2'b01, "R3");
          else if (p[1:0] == 2'b11) begin step(2'b10, "R2"); step(2'b11, "R2"); end
          write_pos(16'h8000);
          d = (seq_idx(n[1:0]) - seq_idx(p[1:0]) + 4) % 4;
          if (d == 2) begin
            drive(n[1:0]);
            chk("R6 no count", position, 16'h8000);
            chk("R6 err set", illegal_err, 1);
            repeat (5) @(negedge clk);
            chk("R6 err sticky", illegal_err, 1);
          end else begin
            cur = p[1:0];
            step(n[1:0], d == 1 ? "R2" : "R3");
            chk("R6 err clear on legal", illegal_err, 0);
          end
        end
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule